// File: doc/BRIEF.md
# UART Oversampling Tick Generator

This block makes the 16x oversampling strobe that paces a UART's transmit and receive shifters. It runs from a fixed 100 MHz system clock. There is no terminal-count divider. Instead, a phase accumulator adds a programmable increment on every enabled clock, and each carry out of its top bit produces a single-cycle tick. The increment that gives a wanted line rate is baud * 2^20 / 100e6, truncated. For example, 115200 baud needs an increment of 1207. The fastest rate is clock/16, where the tick fires on nearly every cycle.

Software loads the increment as two bytes. A write to the upper byte only stages that byte. A write to the lower byte commits the staged upper byte and the new lower byte as one value. This way a half-written increment never reaches the accumulator. The committed increment is always visible on a read-back port, so the programmed rate can be recovered with the inverse formula. While the UART enable is low, the accumulator is held at zero, so every enabled stretch starts from the same phase.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset, `incr_rd` reads 0 and `tick16` is low.
- R2: A write with only `wr_hi` asserted leaves `incr_rd` unchanged; the byte is only staged.
- R3: A write with only `wr_lo` asserted sets `incr_rd` to {staged upper byte, `wr_data`} (upper byte in bits 15:8), visible in the cycle after the write edge.
- R4: When `wr_hi` and `wr_lo` are asserted together, the committed value is {`wr_data`, `wr_data`}, and `wr_data` also becomes the staged upper byte for later low-byte writes.
- R5: Starting from a disabled state, after N enabled clock edges with a constant increment I, exactly floor(N*I/65536) ticks have been seen, and the tick after edge k is high exactly when floor(k*I/65536) > floor((k-1)*I/65536).
- R6: With `uart_en` low, `tick16` is low from the next edge, and the accumulator returns to zero phase.
- R7: An increment of zero never produces a tick.
- R8: A new increment committed while enabled takes over from the edge after the low-byte write edge, without resetting the accumulated phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_en | input | 1 | Enable; low holds the accumulator at zero |
| wr_hi | input | 1 | Stage `wr_data` as the increment upper byte |
| wr_lo | input | 1 | Commit staged upper byte with `wr_data` as lower byte |
| wr_data | input | 8 | Byte written to the increment |
| incr_rd | output | 16 | Committed increment read-back |
| tick16 | output | 1 | Single-cycle 16x oversampling strobe |

## Verification
The bench uses the default 16-bit increment. At that width, every tick position over a few thousand cycles can be predicted exactly with integer arithmetic. It sweeps increments across the whole 16-bit range. The sweep includes zero, one, the values around half scale, the all-ones maximum and the 115200-baud value. For each increment it compares every cycle against an arithmetic carry model and also checks the tick total against the closed-form floor. Mid-run rate changes and byte-write ordering are covered with the same model.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    localparam int BYTE_W = 8;

    // Write operation, decoded from {wr_lo, wr_hi}
    typedef enum logic [1:0] {
        WOP_IDLE = 2'b00,
        WOP_HIGH = 2'b01,
        WOP_LOW  = 2'b10,
        WOP_PAIR = 2'b11
    } wr_op_e;

    function automatic wr_op_e decode_wr(input logic hi, input logic lo);
        return wr_op_e'({lo, hi});
    endfunction

endpackage

// File: rtl/baud_incr_regs.sv
module baud_incr_regs
    import baud_tick_pkg::*;
#(
    parameter int INCR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [INCR_W-1:0]     incr_q
);
    localparam int HI_W = INCR_W - BYTE_W;

    logic [HI_W-1:0] stage_hi;
    logic [HI_W-1:0] hi_from_data;
    wr_op_e          op;

    assign hi_from_data = HI_W'(wr_data);
    assign op           = decode_wr(wr_hi, wr_lo);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_hi <= '0;
            incr_q   <= '0;
        end else begin
            case (op)
                WOP_HIGH: stage_hi <= hi_from_data;
                WOP_LOW:  incr_q   <= {stage_hi, wr_data};
                WOP_PAIR: begin
                    stage_hi <= hi_from_data;
                    incr_q   <= {hi_from_data, wr_data};
                end
                default: ;
            endcase
        end
    end

    // R2: without a low-byte write the committed value holds
    assert_hold_without_commit_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_lo |=> $stable(incr_q));

    // R3: a lone low-byte write lands its byte in the low half
    assert_low_byte_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> (incr_q[BYTE_W-1:0] == $past(wr_data)));

endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
    parameter int ACC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ACC_W-1:0]  incr,
    output logic              tick,
    output logic [ACC_W-1:0]  acc_q
);
    logic [ACC_W:0] sum_w;

    assign sum_w = {1'b0, acc_q} + {1'b0, incr};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            acc_q <= sum_w[ACC_W-1:0];
            tick  <= sum_w[ACC_W];
        end
    end

    // R6: disabled means no tick and zero phase on the next cycle
    assert_idle_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!tick && acc_q == '0));

    // R7: a zero increment never carries
    assert_zero_incr_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (incr == '0) |=> !tick);

    // R5: a tick always coincides with the accumulator wrapping downward
    assert_tick_means_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        tick |-> (acc_q < $past(acc_q)));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int INCR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uart_en,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [7:0]        wr_data,
    output logic [INCR_W-1:0] incr_rd,
    output logic              tick16
);
    logic [INCR_W-1:0] acc_w;

    baud_incr_regs #(.INCR_W(INCR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .incr_q  (incr_rd)
    );

    baud_phase_acc #(.ACC_W(INCR_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .en    (uart_en),
        .incr  (incr_rd),
        .tick  (tick16),
        .acc_q (acc_w)
    );

    // R1: outputs quiet in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (incr_rd == '0 && !tick16));

endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        uart_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic        wr_lo = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] incr_rd;
    logic        tick16;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    baud_tick_gen u0 (
        .clk(clk), .rst(rst), .uart_en(uart_en), .wr_hi(wr_hi),
        .wr_lo(wr_lo), .wr_data(wr_data), .incr_rd(incr_rd), .tick16(tick16)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input bit hi, input bit lo, input logic [7:0] d);
        @(negedge clk);
        wr_hi = hi; wr_lo = lo; wr_data = d;
        @(negedge clk);
        wr_hi = 0; wr_lo = 0;
    endtask

    task automatic load(input logic [15:0] v);
        wr_byte(1, 0, v[15:8]);
        wr_byte(0, 1, v[7:0]);
    endtask

    // Run n enabled edges; optional switch to inc2 with low write at iteration sw
    task automatic run(input logic [15:0] inc1, input logic [15:0] inc2, input int n, input int sw);
        longint acc_m = 0;
        longint cur = inc1;
        longint total = 0;
        longint exp_total;
        bit seq_ok = 1;
        int bad_k = -1;
        bit bad_act = 0, bad_exp = 0;
        load(inc1);
        check(incr_rd == inc1, "R3", incr_rd, inc1);
        @(negedge clk);
        uart_en = 1;
        for (int k = 0; k < n; k++) begin
            if (sw >= 0 && k == sw - 1) begin wr_hi = 1; wr_data = inc2[15:8]; end
            if (sw >= 0 && k == sw) begin wr_hi = 0; wr_lo = 1; wr_data = inc2[7:0]; end
            if (sw >= 0 && k == sw + 1) wr_lo = 0;
            @(posedge clk);
            @(negedge clk);
            begin
                longint s;
                bit e;
                s = acc_m + cur;
                e = (s >= 65536);
                acc_m = s % 65536;
                if (tick16 !== e && seq_ok) begin
                    seq_ok = 0; bad_k = k; bad_act = tick16; bad_exp = e;
                end
                if (tick16) total++;
            end
            if (sw >= 0 && k == sw) cur = inc2;
        end
        uart_en = 0;
        wr_hi = 0; wr_lo = 0;
        if (sw < 0) begin
            exp_total = (longint'(n) * inc1) >> 16;
            check(seq_ok, "R5 per-cycle", bad_act, bad_exp);
            if (!seq_ok) $display("  at edge %0d inc %0d", bad_k, inc1);
            if (inc1 == 0) check(total == 0, "R7", total, 0);
            else check(total == exp_total, "R5 total", total, exp_total);
        end else begin
            exp_total = ((longint'(sw) + 1) * inc1 + (longint'(n) - sw - 1) * inc2) >> 16;
            check(seq_ok, "R8 per-cycle", bad_act, bad_exp);
            check(total == exp_total, "R8 total", total, exp_total);
        end
        @(negedge clk);
        check(tick16 == 0, "R6", tick16, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(incr_rd == 0, "R1 incr", incr_rd, 0);
        check(tick16 == 0, "R1 tick", tick16, 0);

        wr_byte(1, 0, 8'h12);
        check(incr_rd == 0, "R2", incr_rd, 0);
        wr_byte(0, 1, 8'h34);
        check(incr_rd == 16'h1234, "R3", incr_rd, 16'h1234);
        wr_byte(1, 0, 8'hAB);
        check(incr_rd == 16'h1234, "R2 staged", incr_rd, 16'h1234);
        wr_byte(0, 1, 8'hCD);
        check(incr_rd == 16'hABCD, "R3", incr_rd, 16'hABCD);
        wr_byte(1, 1, 8'h5A);
        check(incr_rd == 16'h5A5A, "R4 pair", incr_rd, 16'h5A5A);
        wr_byte(0, 1, 8'h01);
        check(incr_rd == 16'h5A01, "R4 staged", incr_rd, 16'h5A01);

        // Increment held at zero while enabled: R7
        run(16'd0, 16'd0, 1500, -1);

        // Sweep of increments: R5, R6 after each run
        run(16'd1, 16'd0, 1500, -1);
        run(16'd3, 16'd0, 1500, -1);
        run(16'd255, 16'd0, 1500, -1);
        run(16'd256, 16'd0, 1500, -1);
        run(16'd1207, 16'd0, 2000, -1);
        run(16'd4096, 16'd0, 1500, -1);
        run(16'd32767, 16'd0, 1500, -1);
        run(16'd32768, 16'd0, 1500, -1);
        run(16'd32769, 16'd0, 1500, -1);
        run(16'd65534, 16'd0, 1500, -1);
        run(16'd65535, 16'd0, 1500, -1);
        for (int v = 7; v < 65536; v += 6553) run(16'(v), 16'd0, 1200, -1);

        // Mid-run rate change keeps phase: R8
        run(16'd1207, 16'd40000, 1500, 700);
        run(16'd50000, 16'd3, 1500, 333);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule